// File: doc/BRIEF.md
# Unaligned Byte-to-Word Write Packer

This block sits between a byte-oriented write source and a programmer that only accepts whole, aligned 32-bit words. A run is started with a byte address and a byte count; the bytes then arrive on a valid/ready stream. The packer gathers them into 4-byte words and hands each word to the programmer as an aligned word address plus data. It waits for the programmer to report success or failure before it continues.

Flash programming can only clear bits. Every byte lane that the run does not cover is therefore sent as 0xFF, which leaves that part of the flash unchanged, so the packer never has to read the old contents and merge them. A run can start or end in the middle of a word. The first word and the last word may each carry only some real bytes.

A running count reports how many bytes have been committed, meaning they belong to words the programmer accepted as successful. A failed word program ends the run with an error. The count then keeps only the bytes that had already been committed. Completion is a one-cycle pulse that carries the error flag.

Top module: `byte_word_packer`

## Requirements
- R1: Every word request is issued at an address whose two low bits are zero. When the start address is not aligned, the first word goes to the start address rounded down, and its lanes below the start offset carry 0xFF.
- R2: In the first word of an unaligned run, bytes fill lanes from the start offset upward. If the data runs out before lane 3, the remaining upper lanes carry 0xFF.
- R3: After the first word, each group of four bytes is issued as one full word, and each word address is the previous one plus 4.
- R4: A trailing group of 1 to 3 bytes is issued as one word. Those bytes sit in the low lanes and 0xFF fills the lanes above them.
- R5: A start with a byte count of zero raises done with error low in the next cycle. It issues no word and leaves the byte count at 0.
- R6: A word program reported as failed (wr_fail high with wr_ack) ends the run: done and error go high in the next cycle and no further word or byte is taken. bytes_done keeps only the bytes of earlier successful words.
- R7: Byte lane n (address offset n within the word) occupies wr_data bits 8n+7:8n, which is little-endian packing.
- R8: in_ready is low in every cycle in which a word request is outstanding (wr_req high).
- R9: Once raised, wr_req, wr_addr and wr_data hold steady until the cycle in which wr_ack is sampled high.
- R10: bytes_done is cleared by start. It rises, on each successful acknowledge, by the number of real bytes in that word. done is a single-cycle pulse one cycle after the final acknowledge.
- R11: After reset, wr_req, in_ready, done and error are low and bytes_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when the packer is idle; ignored while a run is in progress |
| start_addr | input | AW (32) | Byte address of the first byte |
| byte_len | input | LW (16) | Number of bytes in the run |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | 8 | Byte value |
| in_ready | output | 1 | The packer takes the offered byte this cycle |
| wr_req | output | 1 | A word program request is outstanding |
| wr_addr | output | AW (32) | Aligned word address of the request |
| wr_data | output | 32 | Word to program, lane 0 in bits 7:0 |
| wr_ack | input | 1 | Programmer finished the outstanding word |
| wr_fail | input | 1 | Qualifies wr_ack: the word program failed |
| bytes_done | output | LW (16) | Bytes committed by successful word programs in this run |
| done | output | 1 | One-cycle pulse at the end of a run |
| error | output | 1 | The run ended on a failed word program; valid with done, held until the next start |

## Verification
Two functions can fall in the same cycle: a new byte offered by the source, and the acknowledge that retires the outstanding word. The bench holds in_valid high throughout some runs while the programmer acknowledges with varying delays, so an acknowledge often coincides with a waiting byte. It then checks that the byte is not consumed in that cycle, and that it lands in lane 0 of the next word, or in no word at all when the acknowledge reports failure. A reference model in the bench builds the expected word list from the start address, count and byte values, and compares requests, ready and the committed count on every cycle.

// File: rtl/packer_pkg.sv
// Shared types for the byte-to-word write packer.
// Assumes byte lanes of 8 bits; the word size is set by the users' parameters.
package packer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for start
        ST_FILL  = 2'd1,   // collecting bytes into the word buffer
        ST_ISSUE = 2'd2,   // word request outstanding
        ST_FIN   = 2'd3    // one-cycle completion
    } pk_state_t;

    localparam logic [7:0] PAD_BYTE = 8'hFF;

endpackage

// File: rtl/pk_lane_buf.sv
// Word assembly buffer: one byte register per lane.
// Every lane is reset to the pad value by clear; one lane is written per
// cycle at most. Assumes clear and a write never coincide.
module pk_lane_buf #(
    parameter int NL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic [$clog2(NL)-1:0] lane_sel,
    input  logic [7:0]        din,
    output logic [NL*8-1:0]   word
);
    import packer_pkg::*;

    localparam int LANE_W = $clog2(NL);

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [7:0] lane_q;
        // Hold one byte lane; pad on reset or clear, load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                lane_q <= PAD_BYTE;
            else if (we && lane_sel == LANE_W'(g))
                lane_q <= din;
        end
        assign word[g*8 +: 8] = lane_q;
    end

endmodule

// File: rtl/pk_seq.sv
// Run sequencer: tracks the word address, the lane being filled, the bytes
// left and the bytes committed, and runs the fill/issue handshake.
// Assumes the programmer raises wr_ack for one cycle per request.
module pk_seq #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int NL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [LW-1:0]     byte_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              wr_ack,
    input  logic              wr_fail,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [LW-1:0]     bytes_done,
    output logic              done,
    output logic              error,
    output logic              idle,
    output logic              buf_clear,
    output logic              buf_we,
    output logic [$clog2(NL)-1:0] buf_lane
);
    import packer_pkg::*;

    localparam int LANE_W = $clog2(NL);
    localparam int PEND_W = LANE_W + 1;

    pk_state_t         st;
    logic [AW-1:0]     addr_q;
    logic [LANE_W-1:0] lane_q;
    logic [LW-1:0]     remain_q;
    logic [PEND_W-1:0] pend_q;
    logic [LW-1:0]     count_q;
    logic              err_q;

    logic accept, word_full, ack_ok;

    assign accept    = (st == ST_FILL) && in_valid;
    assign word_full = (lane_q == LANE_W'(NL - 1)) || (remain_q == LW'(1));
    assign ack_ok    = (st == ST_ISSUE) && wr_ack && !wr_fail;

    // Main state, address, lane, remaining and committed counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            addr_q   <= '0;
            lane_q   <= '0;
            remain_q <= '0;
            pend_q   <= '0;
            count_q  <= '0;
            err_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    err_q   <= 1'b0;
                    count_q <= '0;
                    pend_q  <= '0;
                    addr_q  <= {start_addr[AW-1:LANE_W], {LANE_W{1'b0}}};
                    lane_q  <= start_addr[LANE_W-1:0];
                    remain_q <= byte_len;
                    st      <= (byte_len == '0) ? ST_FIN : ST_FILL;
                end
                ST_FILL: if (accept) begin
                    lane_q   <= lane_q + 1'b1;
                    remain_q <= remain_q - 1'b1;
                    pend_q   <= pend_q + 1'b1;
                    if (word_full) st <= ST_ISSUE;
                end
                ST_ISSUE: if (wr_ack) begin
                    if (wr_fail) begin
                        err_q <= 1'b1;
                        st    <= ST_FIN;
                    end else begin
                        count_q <= count_q + LW'(pend_q);
                        pend_q  <= '0;
                        if (remain_q == '0) begin
                            st <= ST_FIN;
                        end else begin
                            addr_q <= addr_q + AW'(NL);
                            lane_q <= '0;
                            st     <= ST_FILL;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Port-facing decode of the state.
    assign in_ready   = (st == ST_FILL);
    assign wr_req     = (st == ST_ISSUE);
    assign wr_addr    = addr_q;
    assign bytes_done = count_q;
    assign done       = (st == ST_FIN);
    assign error      = err_q;
    assign idle       = (st == ST_IDLE);

    // Buffer control: pad at start and after each successful word.
    assign buf_clear = ((st == ST_IDLE) && start) || ack_ok;
    assign buf_we    = accept;
    assign buf_lane  = lane_q;

endmodule

// File: rtl/byte_word_packer.sv
// Byte-to-word write packer top: turns a byte stream aimed at any byte
// address into aligned word program requests, padding unused lanes with
// 0xFF, and stops on the first failed word.
// Assumes one outstanding request; byte stream is stalled while it is open.
module byte_word_packer #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int NL = 4,
    localparam int DW = NL * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] byte_len,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ack,
    input  logic          wr_fail,
    output logic [LW-1:0] bytes_done,
    output logic          done,
    output logic          error
);
    localparam int LANE_W = $clog2(NL);

    logic              idle;
    logic              buf_clear, buf_we;
    logic [LANE_W-1:0] buf_lane;

    pk_seq #(.AW(AW), .LW(LW), .NL(NL)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_len(byte_len), .in_valid(in_valid), .in_ready(in_ready),
        .wr_ack(wr_ack), .wr_fail(wr_fail), .wr_req(wr_req),
        .wr_addr(wr_addr), .bytes_done(bytes_done), .done(done),
        .error(error), .idle(idle), .buf_clear(buf_clear),
        .buf_we(buf_we), .buf_lane(buf_lane)
    );

    pk_lane_buf #(.NL(NL)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .we(buf_we),
        .lane_sel(buf_lane), .din(in_data), .word(wr_data)
    );

    // R8: no byte is taken while a request is open.
    p_ready_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !in_ready);

    // R9: request fields hold until acknowledged.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R1: word addresses are aligned.
    p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr[LANE_W-1:0] == '0));

    // R6: a failed word ends the run with error, count unchanged.
    p_fail_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && wr_fail) |=> (done && error && $stable(bytes_done)));

    // R10: done lasts one cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: zero-length run completes at once.
    p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && byte_len == '0) |=> (done && !error && bytes_done == '0 && !wr_req));

endmodule

// File: tb/sim_byte_word_packer.sv
module sim_byte_word_packer;
    localparam int AW = 32;
    localparam int LW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] byte_len = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ack = 1'b0;
    logic        wr_fail = 1'b0;
    logic [15:0] bytes_done;
    logic        done;
    logic        error;

    byte_word_packer #(.AW(AW), .LW(LW), .NL(4)) u0 (.*);

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    int unsigned ea[$];
    logic [31:0] ed[$];
    int          en[$];
    int          model_cnt = 0;
    bit          mon_on = 0;
    string       tag = "";
    int          fail_idx = -1;
    int          widx = 0;
    int          ack_delay = 0;
    int          wait_cnt = 0;
    bit          run_over = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Programmer model: acknowledges after ack_delay cycles.
    always @(negedge clk) begin
        wr_ack  = 1'b0;
        wr_fail = 1'b0;
        if (wr_req) begin
            if (wait_cnt == 0) begin
                wr_ack   = 1'b1;
                wr_fail  = (widx == fail_idx);
                widx++;
                wait_cnt = ack_delay;
            end else begin
                wait_cnt--;
            end
        end
    end

    // Model update at the edge: retire words on acknowledge.
    always @(posedge clk) begin
        if (mon_on && wr_req && wr_ack) begin
            if (ea.size() == 0) begin
                chk(0, {tag, " R3 extra word"}, wr_addr, 0);
            end else begin
                if (!wr_fail) model_cnt += en[0];
                void'(ea.pop_front());
                void'(ed.pop_front());
                void'(en.pop_front());
            end
        end
    end

    // Per-cycle comparison, away from the edge.
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            chk(bytes_done == 16'(model_cnt), {tag, " R10 bytes_done"}, 32'(bytes_done), 32'(model_cnt));
            if (wr_req) begin
                chk(!in_ready, {tag, " R8 ready while req"}, 32'(in_ready), 0);
                if (ea.size() != 0) begin
                    chk(wr_addr == ea[0], {tag, " R1/R3 wr_addr"}, wr_addr, ea[0]);
                    chk(wr_data == ed[0], {tag, " R2/R4/R7 wr_data"}, wr_data, ed[0]);
                end
            end
        end
    end

    task automatic run(input string t, input int unsigned addr, input int len,
                       input int fidx, input int delay, input bit gaps);
        logic [7:0] bq[$];
        int off, i, nb, exp_cnt, wi;
        int unsigned base;
        logic [31:0] w;
        bit got_done;
        tag = t;
        for (int k = 0; k < len; k++) bq.push_back(8'(addr + k * 37 + 5));
        // build expected words
        ea.delete(); ed.delete(); en.delete();
        off = int'(addr % 4); base = addr - off; i = 0; exp_cnt = 0; wi = 0;
        while (i < len) begin
            w = 32'hFFFF_FFFF; nb = 0;
            for (int l = off; l < 4 && i < len; l++) begin
                w[8*l +: 8] = bq[i]; i++; nb++;
            end
            if (fidx < 0 || wi < fidx) exp_cnt += nb;
            if (fidx < 0 || wi <= fidx) begin
                ea.push_back(base); ed.push_back(w); en.push_back(nb);
            end
            base += 4; off = 0; wi++;
        end
        fail_idx = fidx; widx = 0; ack_delay = delay; wait_cnt = delay;
        run_over = 0; model_cnt = 0;
        @(negedge clk);
        start = 1'b1; start_addr = addr; byte_len = 16'(len);
        @(negedge clk);
        start = 1'b0;
        mon_on = 1;
        fork
            begin : drv
                int j = 0;
                while (j < len && !run_over) begin
                    if (gaps && (cyc % 3 == 0)) in_valid = 1'b0;
                    else begin in_valid = 1'b1; in_data = bq[j]; end
                    @(posedge clk);
                    if (in_valid && in_ready) j++;
                    @(negedge clk);
                end
                in_valid = 1'b0;
            end
            begin : wt
                got_done = 0;
                for (int c = 0; c < 3000 && !got_done; c++) begin
                    #1;
                    if (done) got_done = 1;
                    else @(negedge clk);
                end
                chk(got_done, {t, " R10 done seen"}, 32'(got_done), 1);
                chk(error == (fidx >= 0), {t, " R6 error flag"}, 32'(error), 32'(fidx >= 0));
                chk(bytes_done == 16'(exp_cnt), {t, " R6/R10 final count"}, 32'(bytes_done), 32'(exp_cnt));
                chk(ea.size() == 0, {t, " R3 all words issued"}, 32'(ea.size()), 0);
                @(negedge clk); #1;
                chk(!done, {t, " R10 done single cycle"}, 32'(done), 0);
                run_over = 1;
            end
        join
        @(negedge clk);
        mon_on = 0;
        if (fidx >= 0)
            chk(!wr_req && !in_ready, {t, " R6 no activity after fail"}, 32'({wr_req, in_ready}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!wr_req && !in_ready && !done && !error, "R11 reset outputs",
            32'({wr_req, in_ready, done, error}), 0);
        chk(bytes_done == 0, "R11 reset count", 32'(bytes_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run("R3 aligned full words", 32'h100, 8, -1, 0, 0);
        run("R2 R1 partial first word", 32'h201, 2, -1, 1, 0);
        run("R1 R4 R7 spanning unaligned", 32'h303, 6, -1, 0, 1);
        run("R4 trailing three", 32'h400, 3, -1, 2, 0);
        run("R5 zero length", 32'h555, 0, -1, 0, 0);
        run("R6 fail on second word", 32'h502, 10, 1, 1, 0);
        run("R6 fail on first word", 32'h600, 7, 0, 0, 0);
        run("R8 R9 slow acks with gaps", 32'h701, 13, -1, 3, 1);
        run("R3 long aligned", 32'h800, 40, -1, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule